// File: doc/BRIEF.md
# Periodic Wake Timer

This block raises a periodic wake-up interrupt from a free-running oscillator clock. A two-stage divider first scales the clock by a power of two, then counts a small modulus of those prescaled ticks. When both stages wrap, the block sets a sticky timeout flag. If software has enabled the interrupt, the flag also drives the interrupt request. A 7-bit rate register chooses the exponent and the modulus. Any write to it restarts the period, so software can realign the wake-ups at will.

Two low-power inputs decide what the dividers do when the system sleeps. In pseudo-stop, the timer either keeps running or freezes with its partial count intact, depending on a run enable. In wait mode with stop-in-wait selected, the dividers are forced back to zero instead, so the next period starts fresh once the system wakes.

Top module: `periodic_wake_timer`

## Requirements
- R1: After synchronous reset, both registers read 0, the flag is 0 and the interrupt request is 0.
- R2: With reg_sel = 0 the rate register is selected. Writes store bits 6..0, and the read returns bit 7 as 0 with bits 6..0 as stored. Reads and writes are allowed at any time.
- R3: Rate bits 6..4 give the exponent e (1..7) and bits 3..0 give m. The flag sets exactly (m+1)·2^(BASE_SHIFT+e) clock edges after the edge that wrote the rate register. The counters then restart from zero, so later timeouts follow at the same exact period.
- R4: An exponent of 0 disables the timer. No timeout occurs and the counters stay at zero.
- R5: Every write to the rate register restarts the period, even when the written value equals the stored one.
- R6: In pseudo-stop with the run enable at 0, the dividers hold their value without resetting. Counting resumes from that value on exit.
- R7: In pseudo-stop with the run enable at 1, the timer counts as normal.
- R8: In wait mode with stop-in-wait at 1, the dividers are held at zero, and a full period is counted after exit. In wait mode with stop-in-wait at 0, counting continues.
- R9: With reg_sel = 1 the status register is selected: bit 0 is the flag and bit 1 is the interrupt enable. Writing 1 to bit 0 clears the flag and writing 0 leaves it unchanged. A timeout in the same cycle as a clear wins.
- R10: The interrupt request is high exactly when the flag and the interrupt enable are both 1.
- R11: A write to the status register does not disturb the period in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 rate, 1 status |
| wr_data | input | DATA_W | Write data |
| pstop | input | 1 | Pseudo-stop mode active |
| pstop_run | input | 1 | Keep counting during pseudo-stop |
| wait_mode | input | 1 | Wait mode active |
| wait_stop | input | 1 | Stop and reinitialise dividers in wait mode |
| tmo_flag | output | 1 | Sticky timeout flag |
| irq | output | 1 | Interrupt request |
| rd_data | output | DATA_W | Read value of the selected register |

## Verification
Some properties hold on every cycle, and the assertions check those:
- a freeze leaves both counters unchanged;
- a wait-mode stop or a rate write zeroes them;
- a disabled exponent never produces a timeout;
- the flag stays set until it is cleared;
- a request is never raised without the flag.

Other behaviour can only be shown by the bench's scenarios:
- the exact period length for each rate;
- resuming a partial count after a freeze;
- the full period after a wait stop;
- set winning over a clear on the timeout edge;
- status writes leaving the period alone.

// File: rtl/pwt_pkg.sv
package pwt_pkg;

    localparam int EXP_W   = 3;
    localparam int MOD_W   = 4;
    localparam int RATE_W  = EXP_W + MOD_W;
    localparam int MAX_EXP = (1 << EXP_W) - 1;

    localparam int STAT_FLAG_BIT = 0;
    localparam int STAT_IEN_BIT  = 1;

    typedef struct packed {
        logic [EXP_W-1:0] expo;
        logic [MOD_W-1:0] modsel;
    } rate_t;

    typedef enum logic {
        SEL_RATE = 1'b0,
        SEL_STAT = 1'b1
    } reg_sel_e;

    typedef enum logic [1:0] {
        ACT_RUN   = 2'd0,
        ACT_HOLD  = 2'd1,
        ACT_CLEAR = 2'd2
    } cnt_act_e;

    // Clear beats hold: restart and wait-stop reinitialise, pseudo-stop freezes.
    function automatic cnt_act_e pick_action(
        input logic rate_wr,
        input logic disabled,
        input logic wait_mode,
        input logic wait_stop,
        input logic pstop,
        input logic pstop_run
    );
        if (rate_wr || disabled || (wait_mode && wait_stop))
            return ACT_CLEAR;
        if (pstop && !pstop_run)
            return ACT_HOLD;
        return ACT_RUN;
    endfunction

endpackage

// File: rtl/pwt_regs.sv
module pwt_regs
    import pwt_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              reg_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              timeout,
    output rate_t             rate_q,
    output logic              flag_q,
    output logic              ien_q,
    output logic              rate_wr,
    output logic [DATA_W-1:0] rd_data
);

    logic stat_wr;
    logic flag_clr;
    logic unused_hi;

    assign rate_wr   = wr_en && (reg_sel_e'(reg_sel) == SEL_RATE);
    assign stat_wr   = wr_en && (reg_sel_e'(reg_sel) == SEL_STAT);
    assign flag_clr  = stat_wr && wr_data[STAT_FLAG_BIT];
    assign unused_hi = ^wr_data[DATA_W-1:RATE_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            rate_q <= '0;
            flag_q <= 1'b0;
            ien_q  <= 1'b0;
        end else begin
            if (rate_wr)
                rate_q <= rate_t'(wr_data[RATE_W-1:0]);
            if (stat_wr)
                ien_q <= wr_data[STAT_IEN_BIT];
            if (timeout)
                flag_q <= 1'b1;
            else if (flag_clr)
                flag_q <= 1'b0;
        end
    end

    always_comb begin
        rd_data = '0;
        case (reg_sel_e'(reg_sel))
            SEL_RATE: rd_data[RATE_W-1:0] = rate_q;
            SEL_STAT: begin
                rd_data[STAT_FLAG_BIT] = flag_q;
                rd_data[STAT_IEN_BIT]  = ien_q;
            end
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: rtl/pwt_prescaler.sv
module pwt_prescaler
    import pwt_pkg::*;
#(
    parameter int BASE_SHIFT = 9,
    parameter int PW         = BASE_SHIFT + MAX_EXP
) (
    input  logic             clk,
    input  logic             rst,
    input  cnt_act_e         act,
    input  logic [EXP_W-1:0] expo,
    output logic [PW-1:0]    cnt,
    output logic             tick
);

    localparam logic [PW-1:0] ALL_ONES = '1;

    logic [PW-1:0]    limit;
    logic [EXP_W-1:0] drop;

    // Terminal count is 2^(BASE_SHIFT+expo)-1: all ones shifted right.
    assign drop  = EXP_W'(MAX_EXP) - expo;
    assign limit = ALL_ONES >> drop;
    assign tick  = (act == ACT_RUN) && (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else begin
            case (act)
                ACT_CLEAR: cnt <= '0;
                ACT_HOLD:  cnt <= cnt;
                default:   cnt <= tick ? '0 : cnt + 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/pwt_modcounter.sv
module pwt_modcounter
    import pwt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  cnt_act_e         act,
    input  logic             tick,
    input  logic [MOD_W-1:0] modsel,
    output logic [MOD_W-1:0] cnt,
    output logic             timeout
);

    assign timeout = tick && (cnt == modsel);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else begin
            case (act)
                ACT_CLEAR: cnt <= '0;
                ACT_HOLD:  cnt <= cnt;
                default: begin
                    if (tick)
                        cnt <= timeout ? '0 : cnt + 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/periodic_wake_timer.sv
module periodic_wake_timer
    import pwt_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int BASE_SHIFT = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              reg_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              pstop,
    input  logic              pstop_run,
    input  logic              wait_mode,
    input  logic              wait_stop,
    output logic              tmo_flag,
    output logic              irq,
    output logic [DATA_W-1:0] rd_data
);

    localparam int PW = BASE_SHIFT + MAX_EXP;

    rate_t            rate_q;
    logic             ien_q;
    logic             rate_wr;
    logic             timeout;
    logic             tick;
    cnt_act_e         act;
    logic [PW-1:0]    presc_cnt;
    logic [MOD_W-1:0] mod_cnt;

    assign act = pick_action(rate_wr, (rate_q.expo == '0), wait_mode,
                             wait_stop, pstop, pstop_run);

    pwt_regs #(.DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .reg_sel (reg_sel),
        .wr_data (wr_data),
        .timeout (timeout),
        .rate_q  (rate_q),
        .flag_q  (tmo_flag),
        .ien_q   (ien_q),
        .rate_wr (rate_wr),
        .rd_data (rd_data)
    );

    pwt_prescaler #(.BASE_SHIFT(BASE_SHIFT), .PW(PW)) u_presc (
        .clk  (clk),
        .rst  (rst),
        .act  (act),
        .expo (rate_q.expo),
        .cnt  (presc_cnt),
        .tick (tick)
    );

    pwt_modcounter u_mod (
        .clk     (clk),
        .rst     (rst),
        .act     (act),
        .tick    (tick),
        .modsel  (rate_q.modsel),
        .cnt     (mod_cnt),
        .timeout (timeout)
    );

    assign irq = tmo_flag && ien_q;

endmodule

// File: rtl/pwt_checker.sv
module pwt_checker
    import pwt_pkg::*;
#(
    parameter int PW = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic             reg_sel,
    input logic             wr_bit0,
    input logic             rd_bit7,
    input logic             pstop,
    input logic             pstop_run,
    input logic             wait_mode,
    input logic             wait_stop,
    input logic             tmo_flag,
    input logic             irq,
    input logic             timeout,
    input logic [EXP_W-1:0] expo,
    input logic [PW-1:0]    presc_cnt,
    input logic [MOD_W-1:0] mod_cnt
);

    logic rate_w;
    logic clr_w;
    logic frozen;

    assign rate_w = wr_en && !reg_sel;
    assign clr_w  = wr_en && reg_sel && wr_bit0;
    assign frozen = pstop && !pstop_run && !rate_w &&
                    !(wait_mode && wait_stop) && (expo != '0);

    assert_rate_msb_R2: assert property (@(posedge clk) disable iff (rst)
        !reg_sel |-> !rd_bit7);

    assert_set_on_timeout_R3: assert property (@(posedge clk) disable iff (rst)
        timeout |=> tmo_flag);

    assert_disabled_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        (expo == '0) |-> !timeout);

    assert_restart_zero_R5: assert property (@(posedge clk) disable iff (rst)
        rate_w |=> (presc_cnt == '0) && (mod_cnt == '0));

    assert_freeze_hold_R6: assert property (@(posedge clk) disable iff (rst)
        frozen |=> $stable(presc_cnt) && $stable(mod_cnt));

    assert_wait_reinit_R8: assert property (@(posedge clk) disable iff (rst)
        (wait_mode && wait_stop) |=> (presc_cnt == '0) && (mod_cnt == '0));

    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (tmo_flag && !clr_w) |=> tmo_flag);

    assert_irq_needs_flag_R10: assert property (@(posedge clk) disable iff (rst)
        irq |-> tmo_flag);

endmodule

bind periodic_wake_timer pwt_checker #(.PW(PW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .reg_sel   (reg_sel),
    .wr_bit0   (wr_data[0]),
    .rd_bit7   (rd_data[7]),
    .pstop     (pstop),
    .pstop_run (pstop_run),
    .wait_mode (wait_mode),
    .wait_stop (wait_stop),
    .tmo_flag  (tmo_flag),
    .irq       (irq),
    .timeout   (timeout),
    .expo      (rate_q.expo),
    .presc_cnt (presc_cnt),
    .mod_cnt   (mod_cnt)
);

// File: tb/sim_periodic_wake_timer.sv
`timescale 1ns/1ps
module sim_periodic_wake_timer;

    localparam int BASE = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       reg_sel = 1'b0;
    logic [7:0] wr_data = '0;
    logic       pstop = 1'b0;
    logic       pstop_run = 1'b0;
    logic       wait_mode = 1'b0;
    logic       wait_stop = 1'b0;
    logic       tmo_flag;
    logic       irq;
    logic [7:0] rd_data;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  ien_sh = 1'b0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    periodic_wake_timer #(.DATA_W(8), .BASE_SHIFT(BASE)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .reg_sel(reg_sel),
        .wr_data(wr_data), .pstop(pstop), .pstop_run(pstop_run),
        .wait_mode(wait_mode), .wait_stop(wait_stop),
        .tmo_flag(tmo_flag), .irq(irq), .rd_data(rd_data)
    );

    function automatic int period(int e, int m);
        return (m + 1) << (BASE + e);
    endfunction

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(bit sel, logic [7:0] d);
        wr_en = 1'b1; reg_sel = sel; wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(bit sel, output logic [7:0] v);
        reg_sel = sel;
        #0.5;
        v = rd_data;
    endtask

    task automatic clear_flag();
        wr(1'b1, {6'b0, ien_sh, 1'b1});
    endtask

    // Rate write, then a flag clear: one edge has elapsed since the restart.
    task automatic start(int e, int m);
        wr(1'b0, {1'b0, 3'(e), 4'(m)});
        clear_flag();
    endtask

    task automatic expect_period(string req, int n);
        step(n - 2);
        check(req, tmo_flag, 0);
        step(1);
        check(req, tmo_flag, 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int n;
        void'($urandom(32'h5eed_1234));
        step(3);
        rst = 1'b0;
        step(1);

        // R1 reset state
        rd(1'b0, v); check("R1 rate", v, 0);
        rd(1'b1, v); check("R1 status", v, 0);
        check("R1 flag", tmo_flag, 0);
        check("R1 irq", irq, 0);

        // R2 read-back, bit 7 reads 0
        wr(1'b0, 8'hFF); rd(1'b0, v); check("R2 msb", v, 8'h7F);
        wr(1'b0, 8'h35); rd(1'b0, v); check("R2 value", v, 8'h35);

        // R3 directed, then exact repeat
        ien_sh = 1'b0;
        start(1, 0);
        n = period(1, 0);
        expect_period("R3 first", n);
        clear_flag();
        expect_period("R3 repeat", n);

        // R3 / R10 random rates
        for (int i = 0; i < 8; i++) begin
            int e = 1 + int'($urandom_range(3));
            int m = int'($urandom_range(15));
            ien_sh = 1'($urandom_range(1));
            start(e, m);
            expect_period("R3 random", period(e, m));
            check("R10 irq", irq, int'(ien_sh));
        end

        // R9 set wins over clear on the timeout edge; writing 0 keeps flag
        ien_sh = 1'b1;
        start(1, 0);
        step(period(1, 0) - 2);
        check("R9 pre", tmo_flag, 0);
        clear_flag();
        check("R9 set-wins", tmo_flag, 1);
        check("R10 irq on", irq, 1);
        wr(1'b1, 8'h02);
        check("R9 write-0", tmo_flag, 1);
        rd(1'b1, v); check("R9 status", v, 3);
        clear_flag();
        check("R9 cleared", tmo_flag, 0);
        check("R10 irq off", irq, 0);
        wr(1'b1, 8'h00);
        ien_sh = 1'b0;

        // R4 disabled exponent
        wr(1'b0, 8'h05);
        clear_flag();
        step(2000);
        check("R4 idle", tmo_flag, 0);

        // R5 rewrite of same value restarts
        start(1, 3);
        step(20);
        start(1, 3);
        expect_period("R5 restart", period(1, 3));

        // R11 status write mid-period
        start(2, 1);
        n = period(2, 1);
        step(5);
        wr(1'b1, 8'h02);
        step(n - 8);
        check("R11 early", tmo_flag, 0);
        step(1);
        check("R11 on-time", tmo_flag, 1);
        ien_sh = 1'b1;

        // R6 freeze keeps partial count
        start(2, 2);
        n = period(2, 2);
        step(10);
        pstop = 1'b1; pstop_run = 1'b0;
        step(30);
        check("R6 frozen", tmo_flag, 0);
        pstop = 1'b0;
        step(n - 12);
        check("R6 early", tmo_flag, 0);
        step(1);
        check("R6 resume", tmo_flag, 1);

        // R7 pseudo-stop with run enable
        pstop = 1'b1; pstop_run = 1'b1;
        start(2, 2);
        expect_period("R7 run", n);
        pstop = 1'b0; pstop_run = 1'b0;

        // R8 wait stop reinitialises
        start(2, 2);
        step(10);
        wait_mode = 1'b1; wait_stop = 1'b1;
        step(20);
        wait_mode = 1'b0; wait_stop = 1'b0;
        step(n - 1);
        check("R8 early", tmo_flag, 0);
        step(1);
        check("R8 full", tmo_flag, 1);

        // R8 wait without stop keeps counting
        wait_mode = 1'b1;
        start(2, 2);
        expect_period("R8 wait-run", n);
        wait_mode = 1'b0;

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule